// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

A bank of one-bit token flags shared between a left and a right processor port, both in one clock domain. Software on either side claims a shared resource by writing 0 to a flag and then reading the flag back. A read of 0 means the reading side now holds the token. A read of 1 means the other side holds it, or that the flag is free and was never requested.

A request that loses stays pending inside the unit. When the owner releases the token by writing 1, the pending request is granted on that same clock edge. Neither port is ever stalled. The unit only records and reports ownership and does not control any resource itself.

Each port has a select, a write enable, a flag address and one data bit. A write carries the data bit. A read returns its result on a registered data output.

Top module: `sem_unit`

## Requirements
- R1: After reset every flag is free with no pending request, and it reads 1 from both sides.
- R2: A write of 0 (select=1, write enable=1, data=0) to a free flag makes the writing side the owner. The owner then reads 0 and the other side reads 1. A repeated write of 0 by the owner changes nothing.
- R3: A read (select=1, write enable=0) loads the flag as seen by the reading side into that side's data output one clock after the access. The value is taken before the updates of that same edge. The output holds between reads.
- R4: When both sides write 0 to the same free flag in the same cycle, the left side becomes the owner. A write of 0 from the non-owner never takes ownership: that side reads 1 and its request stays pending.
- R5: A write of 1 from the owner releases the flag. With no request pending, it then reads 1 from both sides.
- R6: When the owner releases a flag while the other side has a request pending, the other side becomes the owner on that same edge and reads 0 on its next read.
- R7: A write of 1 from the non-owner cancels that side's pending request and leaves the owner in place. A later release then leaves the flag free.
- R8: A write of 1 to a free flag, or from a side that has nothing pending, has no effect.
- R9: Each flag is independent. An access at one address never changes the state of another flag.
- R10: With select low, a port's write enable, address and data have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_i | input | 1 | Left port flag select |
| l_we_i | input | 1 | Left port write enable (0 = read) |
| l_addr_i | input | ADDR_W (3) | Left port flag address |
| l_wdata_i | input | 1 | Left port write data (0 = request, 1 = release/withdraw) |
| l_rdata_o | output | 1 | Left port read data (0 = left owns) |
| r_sel_i | input | 1 | Right port flag select |
| r_we_i | input | 1 | Right port write enable (0 = read) |
| r_addr_i | input | ADDR_W (3) | Right port flag address |
| r_wdata_i | input | 1 | Right port write data |
| r_rdata_o | output | 1 | Right port read data (0 = right owns) |

## Verification
A write changes ownership on the clock edge that ends its access cycle. A read started in the following cycle shows the new state on the read data output one cycle after that read. A hand-off after a release is therefore visible on the very next read by the waiting side. The driver records each expected read value with a due cycle set to the access cycle plus one. The monitor compares it shortly after that edge. A read driven in the same cycle as a write to the same flag is expected to return the state before that write.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wdata_i,
  output logic [NUM_FLAGS-1:0] set_o,
  output logic [NUM_FLAGS-1:0] clr_o
);
  logic wr;
  assign wr = sel_i & we_i;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
    logic hit;
    assign hit      = wr && (addr_i == ADDR_W'(g));
    assign set_o[g] = hit & ~wdata_i;
    assign clr_o[g] = hit &  wdata_i;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l_set_i,
  input  logic l_clr_i,
  input  logic r_set_i,
  input  logic r_clr_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic   req_l, req_r, rel, free_eff;

  always_comb begin
    req_l    = l_set_i | (pend_l_q & ~l_clr_i);
    req_r    = r_set_i | (pend_r_q & ~r_clr_i);
    rel      = (owner_q == OWN_LEFT  && l_clr_i) ||
               (owner_q == OWN_RIGHT && r_clr_i);
    free_eff = (owner_q == OWN_NONE) || rel;
    owner_d  = owner_q;
    if (free_eff) begin
      // left has fixed priority on a tie
      if (req_l)      owner_d = OWN_LEFT;
      else if (req_r) owner_d = OWN_RIGHT;
      else            owner_d = OWN_NONE;
    end
    pend_l_d = req_l && (owner_d != OWN_LEFT);
    pend_r_d = req_r && (owner_d != OWN_RIGHT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);

  a_r2_free_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && r_set_i && !l_set_i) |=> (owner_q == OWN_RIGHT));
  a_r4_left_priority: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && l_set_i && r_set_i) |=> (owner_q == OWN_LEFT && pend_r_q));
  a_r4_pend_needs_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_l_q || pend_r_q) |-> (owner_q != OWN_NONE));
  a_r6_handoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && l_clr_i && pend_r_q && !r_clr_i) |=> (owner_q == OWN_RIGHT));
  a_r7_withdraw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_LEFT && r_clr_i && !l_clr_i) |=> (owner_q == OWN_LEFT && !pend_r_q));
  a_r8_free_clear_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_q == OWN_NONE && !l_set_i && !r_set_i) |=> (owner_q == OWN_NONE));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_FLAGS = 8,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_FLAGS-1:0] own_i,
  output logic                 rdata_o
);
  logic rd_en;
  assign rd_en = sel_i & ~we_i;

  // active-low view: 0 means this side owns the token
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= 1'b1;
    else if (rd_en) rdata_o <= ~own_i[addr_i];
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(rdata_o));
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
  parameter int NUM_FLAGS = 8,
  localparam int ADDR_W = $clog2(NUM_FLAGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sel_i,
  input  logic              l_we_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_wdata_i,
  output logic              l_rdata_o,
  input  logic              r_sel_i,
  input  logic              r_we_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_wdata_i,
  output logic              r_rdata_o
);
  logic [NUM_FLAGS-1:0] l_set, l_clr, r_set, r_clr, own_l, own_r;

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
    .sel_i(l_sel_i), .we_i(l_we_i), .addr_i(l_addr_i), .wdata_i(l_wdata_i),
    .set_o(l_set), .clr_o(l_clr)
  );
  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
    .sel_i(r_sel_i), .we_i(r_we_i), .addr_i(r_addr_i), .wdata_i(r_wdata_i),
    .set_o(r_set), .clr_o(r_clr)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .l_set_i(l_set[g]), .l_clr_i(l_clr[g]),
      .r_set_i(r_set[g]), .r_clr_i(r_clr[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS)) u_rd_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(l_sel_i), .we_i(l_we_i),
    .addr_i(l_addr_i), .own_i(own_l), .rdata_o(l_rdata_o)
  );
  sem_read_port #(.NUM_FLAGS(NUM_FLAGS)) u_rd_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(r_sel_i), .we_i(r_we_i),
    .addr_i(r_addr_i), .own_i(own_r), .rdata_o(r_rdata_o)
  );

  a_r9_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);
  a_r10_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_sel_i && !r_sel_i) |=> ($stable(own_l) && $stable(own_r)));
endmodule

// File: tb/sem_unit_tb_top.sv
`timescale 1ns/1ps
module sem_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       l_sel = 0, l_we = 0, l_wd = 0;
  logic       r_sel = 0, r_we = 0, r_wd = 0;
  logic [2:0] l_addr = 0, r_addr = 0;
  logic       l_rd, r_rd;

  sem_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_i(l_sel), .l_we_i(l_we), .l_addr_i(l_addr), .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_sel_i(r_sel), .r_we_i(r_we), .r_addr_i(r_addr), .r_wdata_i(r_wd), .r_rdata_o(r_rd)
  );

  typedef struct {
    bit    side;
    bit    exp;
    int    due;
    string tag;
  } item_t;
  item_t q[$];

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  // monitor: read results are due one edge after the access
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.due != cyc) chk(1'b0, 1'b1, {it.tag, " (missed due cycle)"});
        else chk(it.side ? r_rd : l_rd, it.exp, it.tag);
      end
    end
  end

  task automatic drive(input bit ls, input bit lw, input logic [2:0] la, input bit ld, input bit el,
                       input bit rs, input bit rw, input logic [2:0] ra, input bit rd, input bit er,
                       input string tag);
    @(negedge clk);
    l_sel = ls; l_we = lw; l_addr = la; l_wd = ld;
    r_sel = rs; r_we = rw; r_addr = ra; r_wd = rd;
    if (ls && !lw) q.push_back('{1'b0, el, cyc + 1, {tag, " [left]"}});
    if (rs && !rw) q.push_back('{1'b1, er, cyc + 1, {tag, " [right]"}});
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic wl(input logic [2:0] a, input bit d);
    drive(1, 1, a, d, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic wr(input logic [2:0] a, input bit d);
    drive(0, 0, 0, 0, 0, 1, 1, a, d, 0, "");
  endtask
  task automatic rl(input logic [2:0] a, input bit e, input string tag);
    drive(1, 0, a, 0, e, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rr(input logic [2:0] a, input bit e, input string tag);
    drive(0, 0, 0, 0, 0, 1, 0, a, 0, e, tag);
  endtask
  task automatic rb(input logic [2:0] a, input bit el, input bit er, input string tag);
    drive(1, 0, a, 0, el, 1, 0, a, 0, er, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(l_rd, 1'b1, "R1 left rdata in reset");
    chk(r_rd, 1'b1, "R1 right rdata in reset");
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) rb(3'(i), 1, 1, "R1 flag free after reset");

    // R2 grab
    wl(2, 0);
    rb(2, 0, 1, "R2 left owns flag 2");
    wl(2, 0);
    rb(2, 0, 1, "R2 repeat request no change");

    // R4 losing request stays pending
    wr(2, 0);
    rb(2, 0, 1, "R4 right request does not take flag 2");

    // R6 hand-off on release; the read in the release cycle sees the old state
    drive(1, 1, 2, 1, 0, 1, 0, 2, 0, 1, "R3 read sees pre-edge state");
    rb(2, 1, 0, "R6 right owns flag 2 after left release");

    // R5 release with nothing pending
    wr(2, 1);
    rb(2, 1, 1, "R5 flag 2 free after right release");

    // R4 tie on free flag 5
    drive(1, 1, 5, 0, 0, 1, 1, 5, 0, 0, "");
    rb(5, 0, 1, "R4 left wins tie on flag 5");

    // R7 withdraw then release
    wr(5, 1);
    rb(5, 0, 1, "R7 withdraw leaves left owner");
    wl(5, 1);
    rb(5, 1, 1, "R7 no hand-off after withdraw");

    // R8 clears with no effect
    wr(6, 1);
    rb(6, 1, 1, "R8 clear of free flag");
    wl(6, 0);
    wr(6, 1);
    rb(6, 0, 1, "R8 non-owner clear without pending");

    // R9 independence
    wr(7, 0);
    rb(7, 1, 0, "R9 right owns flag 7");
    rb(6, 0, 1, "R9 flag 6 unchanged");
    for (int i = 0; i < 6; i++) rb(3'(i), 1, 1, "R9 other flags still free");

    // R10 deselected port
    drive(0, 1, 0, 0, 0, 0, 1, 0, 0, 0, "");
    drive(0, 1, 6, 1, 0, 0, 1, 7, 1, 0, "");
    rb(0, 1, 1, "R10 deselected request ignored");
    rl(6, 0, "R10 deselected release ignored (left)");
    rr(7, 0, "R10 deselected release ignored (right)");

    // R3 hold between reads
    rl(0, 1, "R3 read flag 0");
    rl(6, 0, "R3 read flag 6");
    idle();
    idle();
    @(posedge clk); #2;
    chk(l_rd, 1'b0, "R3 left rdata held after idle");
    chk(r_rd, 1'b0, "R3 right rdata held after idle");

    idle();
    idle();
    idle();
    chk(q.size() == 0, 1'b1, "R3 all reads returned");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule